// File: doc/BRIEF.md
# USB PHY Power and Reset Sequencer

This block walks the control registers of a dual-speed USB PHY through a fixed bring-up and a separate teardown. The PHY has a high-speed transceiver path (UTMI) and a SuperSpeed path (PIPE). The block holds its own flop copies of the PHY control words and drives them straight onto its outputs. A one-cycle start request begins bring-up for the path chosen by `usePipe`, using a 3-bit reference-frequency code. A different one-cycle request begins teardown.

Bring-up runs in a fixed order:
1. Clear the handshake-port and resume words.
2. Program the link-system word.
3. Apply the settings common to both paths.
4. Apply the settings of the chosen path.
5. Write the clock/reset word with the port-reset bit set.
6. Hold port reset for a set number of clock cycles, then release it.

Teardown forces the transceiver into suspend and sleep. It then removes the reference, spread-spectrum and common-block enables and powers down both speed paths. Every sequence ends with a one-cycle `done` pulse. Requests that arrive while a sequence is running are dropped.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, every output word is zero except `param0Word`, which is 0x8000_0000, and `testWord`, which is 0x0000_000C. `done` is low.
- R2: Bring-up leaves `crPortWord` and `resumeWord` at zero. It sets `linkSysWord` to 0x0800_0040: frame-length adjust of 0x20 in bits [6:1], and the version-control bit 27. It clears bit 31 of `param0Word` and sets bit 2 of `utmiClkSelWord`, on either path.
- R3: Bring-up with `usePipe`=0 does four things. It sets `param0Word[30:26]` to 9 and `param1Word[4:0]` to 0x1C. It writes `utmiCtrlWord` as 0x40 (only bit 6 set). It clears `testWord[2]` and leaves `testWord[3]` set.
- R4: Bring-up with `usePipe`=1 sets `param1Word[4:0]` to 0x1C and clears `testWord[3]`. It leaves `testWord[2]` set, `utmiCtrlWord` unchanged and `param0Word[30:26]` unchanged.
- R5: After bring-up, `clkRstWord` has these bits set: 3 in bits [3:2], bit 4, bit 0, bit 20 and bit 19. On the UTMI path, bits [7:5] carry `refCode`.
- R6: On the PIPE path, the multiplier field (bits [17:11]) and the spread-spectrum reference field (bits [30:23]) depend on `refCode`:

  | `refCode` | Multiplier [17:11] | Spread-spectrum ref [30:23] |
  |---|---|---|
  | 7 | 0x32 | 0x00 |
  | 5 | 0x68 | 0x88 |
  | 4 | 0x7D | 0x00 |
  | 3 | 0x02 | 0x88 |
  | any other code | 0 | 0 |

  Bits [10:8] are zero.
- R7: Bit 1 of `clkRstWord` (port reset) stays high for exactly `HOLD_CYCLES` clock cycles. It then returns low, and every other bit keeps its value.
- R8: Teardown writes `utmiCtrlWord` as 0x43: bits 6, 1 and 0. It clears bits 19, 20 and 0 of `clkRstWord` and keeps the rest. It sets bits 3 and 2 of `testWord`.
- R9: When idle, a request starts a sequence on the next cycle. If both requests arrive in the same cycle, bring-up wins. Requests seen while a sequence runs have no effect.
- R10: `done` is high for exactly one cycle at the end of each sequence.
- R11: Port reset rises only after the link-system word and the common settings are in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initReq | input | 1 | Start bring-up (one-cycle request) |
| exitReq | input | 1 | Start teardown (one-cycle request) |
| usePipe | input | 1 | Path select for bring-up: 0 UTMI, 1 PIPE |
| refCode | input | 3 | Reference-frequency code |
| crPortWord | output | 32 | Handshake-port word copy |
| resumeWord | output | 32 | Resume word copy |
| linkSysWord | output | 32 | Link-system word copy |
| utmiCtrlWord | output | 32 | Transceiver control word copy |
| clkRstWord | output | 32 | Clock/reset word copy |
| param0Word | output | 32 | Parameter word 0 copy |
| param1Word | output | 32 | Parameter word 1 copy |
| testWord | output | 32 | Test/power-down word copy |
| utmiClkSelWord | output | 32 | Transceiver clock-select word copy |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with `HOLD_CYCLES` set to 6 instead of its default of 2000. At that value the reset-hold window can be counted cycle by cycle, and a late request can be injected while port reset is still held. The bench keeps the default reset values of the two parameter words, so the clearing of bit 31 and of the power-down bits shows at the ports. With a short window, every supported reference code on both paths fits in a short run. So do a teardown with a request injected mid-sequence and a same-cycle double request.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int REG_W = 32;

  localparam logic [REG_W-1:0] LINK_VAL      = 32'h0800_0040;
  localparam logic [REG_W-1:0] UTMI_RUN_VAL  = 32'h0000_0040;
  localparam logic [REG_W-1:0] UTMI_STOP_VAL = 32'h0000_0043;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_LINK, S_COMMON, S_MODE, S_CLK, S_HOLD,
    S_EXU, S_EXC, S_EXT, S_FIN
  } seqState_e;

  typedef struct packed {
    logic capture;
    logic clrCr;
    logic wrLink;
    logic wrCommon;
    logic wrMode;
    logic wrClk;
    logic relRst;
    logic exUtmi;
    logic exClk;
    logic exTest;
  } seqStrobe_t;

  // SuperSpeed multiplier and spread-spectrum reference per frequency code
  function automatic logic [6:0] pipeMult(input logic [2:0] code);
    case (code)
      3'd7:    pipeMult = 7'h32;
      3'd5:    pipeMult = 7'h68;
      3'd4:    pipeMult = 7'h7D;
      3'd3:    pipeMult = 7'h02;
      default: pipeMult = 7'h00;
    endcase
  endfunction

  function automatic logic [7:0] pipeSsc(input logic [2:0] code);
    case (code)
      3'd5, 3'd3: pipeSsc = 8'h88;
      default:    pipeSsc = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
#(
  parameter int HOLD_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       initReq,
  input  logic       exitReq,
  output seqStrobe_t stb,
  output logic       runExit,
  output logic       done
);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);

  seqState_e state, stateNext;
  logic [HOLD_W-1:0] holdCnt;
  logic busy;

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (initReq) begin
          stb.capture = 1'b1;
          stateNext   = S_CLR;
        end else if (exitReq) begin
          stateNext = S_EXU;
        end
      end
      S_CLR:    begin stb.clrCr    = 1'b1; stateNext = S_LINK;   end
      S_LINK:   begin stb.wrLink   = 1'b1; stateNext = S_COMMON; end
      S_COMMON: begin stb.wrCommon = 1'b1; stateNext = S_MODE;   end
      S_MODE:   begin stb.wrMode   = 1'b1; stateNext = S_CLK;    end
      S_CLK:    begin stb.wrClk    = 1'b1; stateNext = S_HOLD;   end
      S_HOLD: begin
        if (holdCnt == HOLD_LAST) begin
          stb.relRst = 1'b1;
          stateNext  = S_FIN;
        end
      end
      S_EXU: begin stb.exUtmi = 1'b1; stateNext = S_EXC; end
      S_EXC: begin stb.exClk  = 1'b1; stateNext = S_EXT; end
      S_EXT: begin stb.exTest = 1'b1; stateNext = S_FIN; end
      S_FIN:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      holdCnt <= '0;
      runExit <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && (initReq || exitReq)) runExit <= !initReq;
      if (state == S_HOLD && holdCnt != HOLD_LAST) holdCnt <= holdCnt + 1'b1;
      else holdCnt <= '0;
    end
  end

  // R10: done never lasts longer than one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: an idle request starts a sequence on the next cycle
  assert_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (initReq || exitReq)) |=> busy);
endmodule

// File: rtl/phy_seq_regs.sv
module phy_seq_regs
  import phy_seq_pkg::*;
#(
  parameter int               HOLD_CYCLES = 2000,
  parameter logic [REG_W-1:0] PARAM0_RST  = 32'h8000_0000,
  parameter logic [REG_W-1:0] TEST_RST    = 32'h0000_000C
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic             usePipe,
  input  logic [2:0]       refCode,
  output logic [REG_W-1:0] crPortQ,
  output logic [REG_W-1:0] resumeQ,
  output logic [REG_W-1:0] linkQ,
  output logic [REG_W-1:0] utmiCtrlQ,
  output logic [REG_W-1:0] clkRstQ,
  output logic [REG_W-1:0] param0Q,
  output logic [REG_W-1:0] param1Q,
  output logic [REG_W-1:0] testQ,
  output logic [REG_W-1:0] clkSelQ
);
  localparam int CHK_W = $clog2(HOLD_CYCLES + 2);

  logic       pipeQ;
  logic [2:0] codeQ;
  logic [REG_W-1:0] clkWrVal;

  always_comb begin
    clkWrVal       = clkRstQ;
    clkWrVal[3:2]  = 2'b11;
    if (pipeQ) begin
      clkWrVal[10:8]  = 3'b000;
      clkWrVal[17:11] = pipeMult(codeQ);
      clkWrVal[30:23] = pipeSsc(codeQ);
    end else begin
      clkWrVal[7:5] = codeQ;
    end
    clkWrVal[4]  = 1'b1;
    clkWrVal[0]  = 1'b1;
    clkWrVal[20] = 1'b1;
    clkWrVal[19] = 1'b1;
    clkWrVal[1]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeQ     <= 1'b0;
      codeQ     <= '0;
      crPortQ   <= '0;
      resumeQ   <= '0;
      linkQ     <= '0;
      utmiCtrlQ <= '0;
      clkRstQ   <= '0;
      param0Q   <= PARAM0_RST;
      param1Q   <= '0;
      testQ     <= TEST_RST;
      clkSelQ   <= '0;
    end else begin
      if (stb.capture) begin
        pipeQ <= usePipe;
        codeQ <= refCode;
      end
      if (stb.clrCr) begin
        crPortQ <= '0;
        resumeQ <= '0;
      end
      if (stb.wrLink) linkQ <= LINK_VAL;
      if (stb.wrCommon) begin
        param0Q[31] <= 1'b0;
        clkSelQ[2]  <= 1'b1;
      end
      if (stb.wrMode) begin
        param1Q[4:0] <= 5'h1C;
        if (pipeQ) begin
          testQ[3] <= 1'b0;
        end else begin
          param0Q[30:26] <= 5'd9;
          utmiCtrlQ      <= UTMI_RUN_VAL;
          testQ[2]       <= 1'b0;
        end
      end
      if (stb.wrClk)  clkRstQ    <= clkWrVal;
      if (stb.relRst) clkRstQ[1] <= 1'b0;
      if (stb.exUtmi) utmiCtrlQ  <= UTMI_STOP_VAL;
      if (stb.exClk) begin
        clkRstQ[19] <= 1'b0;
        clkRstQ[20] <= 1'b0;
        clkRstQ[0]  <= 1'b0;
      end
      if (stb.exTest) testQ[3:2] <= 2'b11;
    end
  end

  // Checker: length of the current port-reset window
  logic [CHK_W-1:0] heldCnt;
  always_ff @(posedge clk) begin
    if (!rstN)           heldCnt <= '0;
    else if (clkRstQ[1]) heldCnt <= heldCnt + 1'b1;
    else                 heldCnt <= '0;
  end

  // R7: port reset stays high for exactly HOLD_CYCLES cycles
  assert_hold_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkRstQ[1]) |-> heldCnt == CHK_W'(HOLD_CYCLES));

  // R7: release keeps the enable bits
  assert_release_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkRstQ[1]) |-> (clkRstQ[0] && clkRstQ[19] && clkRstQ[20] && clkRstQ[4]));

  // R11: port reset rises only after link and common settings are in place
  assert_rst_order_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkRstQ[1]) |-> (linkQ == LINK_VAL && !param0Q[31] && clkSelQ[2]));
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int          HOLD_CYCLES = 2000,
  parameter logic [31:0] PARAM0_RST  = 32'h8000_0000,
  parameter logic [31:0] TEST_RST    = 32'h0000_000C
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        initReq,
  input  logic        exitReq,
  input  logic        usePipe,
  input  logic [2:0]  refCode,
  output logic [31:0] crPortWord,
  output logic [31:0] resumeWord,
  output logic [31:0] linkSysWord,
  output logic [31:0] utmiCtrlWord,
  output logic [31:0] clkRstWord,
  output logic [31:0] param0Word,
  output logic [31:0] param1Word,
  output logic [31:0] testWord,
  output logic [31:0] utmiClkSelWord,
  output logic        done
);
  seqStrobe_t stb;
  logic runExit;

  phy_seq_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .initReq(initReq), .exitReq(exitReq),
    .stb(stb), .runExit(runExit), .done(done)
  );

  phy_seq_regs #(
    .HOLD_CYCLES(HOLD_CYCLES), .PARAM0_RST(PARAM0_RST), .TEST_RST(TEST_RST)
  ) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .usePipe(usePipe), .refCode(refCode),
    .crPortQ(crPortWord), .resumeQ(resumeWord), .linkQ(linkSysWord),
    .utmiCtrlQ(utmiCtrlWord), .clkRstQ(clkRstWord), .param0Q(param0Word),
    .param1Q(param1Word), .testQ(testWord), .clkSelQ(utmiClkSelWord)
  );

  // R8: teardown ends with suspend/sleep forced and both paths powered down
  assert_exit_state_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && runExit) |-> (utmiCtrlWord == UTMI_STOP_VAL && testWord[3:2] == 2'b11
                           && clkRstWord[20:19] == 2'b00 && !clkRstWord[0]));
endmodule

// File: tb/sim_phy_bringup_seq.sv
module sim_phy_bringup_seq;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initReq = 1'b0, exitReq = 1'b0, usePipe = 1'b0;
  logic [2:0] refCode = 3'd0;
  logic [31:0] crPortWord, resumeWord, linkSysWord, utmiCtrlWord, clkRstWord;
  logic [31:0] param0Word, param1Word, testWord, utmiClkSelWord;
  logic done;

  int checks = 0, errors = 0;
  int rstHigh = 0, doneCnt = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  phy_bringup_seq #(.HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .initReq(initReq), .exitReq(exitReq),
    .usePipe(usePipe), .refCode(refCode), .crPortWord(crPortWord),
    .resumeWord(resumeWord), .linkSysWord(linkSysWord), .utmiCtrlWord(utmiCtrlWord),
    .clkRstWord(clkRstWord), .param0Word(param0Word), .param1Word(param1Word),
    .testWord(testWord), .utmiClkSelWord(utmiClkSelWord), .done(done)
  );

  always @(negedge clk) begin
    if (rstN && clkRstWord[1]) rstHigh++;
    if (rstN && done) doneCnt++;
  end

  typedef struct packed {
    logic        pipe;
    logic [2:0]  code;
    logic [31:0] clkExp;
    logic [31:0] p0Exp;
    logic [31:0] testExp;
    logic [31:0] utmiExp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 3'd5, 32'h0018_00BD, 32'h2400_0000, 32'h0000_0008, 32'h0000_0040},
    '{1'b0, 3'd2, 32'h0018_005D, 32'h2400_0000, 32'h0000_0008, 32'h0000_0040},
    '{1'b1, 3'd7, 32'h0019_901D, 32'h0000_0000, 32'h0000_0004, 32'h0000_0000},
    '{1'b1, 3'd5, 32'h441B_401D, 32'h0000_0000, 32'h0000_0004, 32'h0000_0000},
    '{1'b1, 3'd4, 32'h001B_E81D, 32'h0000_0000, 32'h0000_0004, 32'h0000_0000},
    '{1'b1, 3'd3, 32'h4418_101D, 32'h0000_0000, 32'h0000_0004, 32'h0000_0000},
    '{1'b1, 3'd2, 32'h0018_001D, 32'h0000_0000, 32'h0000_0004, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Pulse the requests for one cycle, then wait for done and one idle cycle.
  task automatic runSeq(input logic doInit, input logic doExit);
    rstHigh = 0;
    doneCnt = 0;
    initReq = doInit;
    exitReq = doExit;
    @(negedge clk);
    initReq = 1'b0;
    exitReq = 1'b0;
    for (int i = 0; i < HOLD + 40 && doneCnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5ns * 100000);
    errors++;
    $display("FAIL R10 watchdog: actual timeout expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R1: reset state
    check("R1 crPort", crPortWord, 32'h0);
    check("R1 resume", resumeWord, 32'h0);
    check("R1 link", linkSysWord, 32'h0);
    check("R1 utmiCtrl", utmiCtrlWord, 32'h0);
    check("R1 clkRst", clkRstWord, 32'h0);
    check("R1 param0", param0Word, 32'h8000_0000);
    check("R1 param1", param1Word, 32'h0);
    check("R1 test", testWord, 32'h0000_000C);
    check("R1 clkSel", utmiClkSelWord, 32'h0);
    check("R1 done", {31'b0, done}, 32'h0);

    // Table walk: bring-up on both paths for each reference code
    for (int v = 0; v < 7; v++) begin
      doReset();
      usePipe = VECS[v].pipe;
      refCode = VECS[v].code;
      runSeq(1'b1, 1'b0);
      check("R2 crPort", crPortWord, 32'h0);
      check("R2 resume", resumeWord, 32'h0);
      check("R2 link", linkSysWord, 32'h0800_0040);
      check("R2 clkSel", utmiClkSelWord, 32'h0000_0004);
      check(VECS[v].pipe ? "R6 clkRst" : "R5 clkRst", clkRstWord, VECS[v].clkExp);
      check(VECS[v].pipe ? "R4 param0" : "R3 param0", param0Word, VECS[v].p0Exp);
      check(VECS[v].pipe ? "R4 param1" : "R3 param1", param1Word, 32'h0000_001C);
      check(VECS[v].pipe ? "R4 test" : "R3 test", testWord, VECS[v].testExp);
      check(VECS[v].pipe ? "R4 utmiCtrl" : "R3 utmiCtrl", utmiCtrlWord, VECS[v].utmiExp);
      check("R7 reset hold", rstHigh, HOLD);
      check("R10 done count", doneCnt, 1);
    end

    // R8: teardown after UTMI bring-up at code 5
    doReset();
    usePipe = 1'b0; refCode = 3'd5;
    runSeq(1'b1, 1'b0);
    runSeq(1'b0, 1'b1);
    check("R8 utmiCtrl", utmiCtrlWord, 32'h0000_0043);
    check("R8 clkRst", clkRstWord, 32'h0000_00BC);
    check("R8 test", testWord, 32'h0000_000C);
    check("R8 no port reset", rstHigh, 0);
    check("R10 exit done count", doneCnt, 1);

    // R9: requests during a running bring-up are dropped
    doReset();
    usePipe = 1'b0; refCode = 3'd5;
    rstHigh = 0; doneCnt = 0;
    initReq = 1'b1;
    @(negedge clk);
    initReq = 1'b0;
    repeat (6) @(negedge clk);   // inside the hold window
    exitReq = 1'b1; initReq = 1'b1;
    @(negedge clk);
    exitReq = 1'b0; initReq = 1'b0;
    for (int i = 0; i < HOLD + 40 && doneCnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R9 utmiCtrl after late req", utmiCtrlWord, 32'h0000_0040);
    check("R9 clkRst after late req", clkRstWord, 32'h0018_00BD);
    check("R9 reset hold", rstHigh, HOLD);
    check("R9 single done", doneCnt, 1);

    // R9: bring-up request during teardown is dropped
    rstHigh = 0; doneCnt = 0;
    exitReq = 1'b1;
    @(negedge clk);
    exitReq = 1'b0; initReq = 1'b1;
    @(negedge clk);
    initReq = 1'b0;
    repeat (10) @(negedge clk);
    check("R9 exit kept", utmiCtrlWord, 32'h0000_0043);
    check("R9 no reset in exit", rstHigh, 0);
    check("R9 exit single done", doneCnt, 1);

    // R9: both requests at once from idle, bring-up wins
    doReset();
    usePipe = 1'b1; refCode = 3'd7;
    runSeq(1'b1, 1'b1);
    check("R9 priority clkRst", clkRstWord, 32'h0019_901D);
    check("R9 priority test", testWord, 32'h0000_0004);
    check("R9 priority hold", rstHigh, HOLD);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule